// File: doc/BRIEF.md
# Fixed-Latency Memory Slave

This block is an AXI4 slave that stands in for main memory on a processor's memory port. It holds a row-organised storage array of 256-bit rows (four 64-bit words each). Addresses arriving on the read and write address channels are first rebased by subtracting a configurable region base. The row index then wraps modulo the array depth, so the whole region aliases onto the array.

At most one read burst and one write burst are in flight at once, and the two proceed independently. Every accepted request waits a fixed, parameterised number of cycles before its response is offered, which imitates DRAM latency. Write beats are gathered into a burst buffer and copied into the array only when the write response handshake completes. Responses echo the request ID and always report OKAY. A sticky error output flags illegal write burst types and a `w_last` that does not match the beat count.

Top module: `lat_mem_slave`

## Requirements
- R1: Out of reset, `aw_ready`, `w_ready`, `ar_ready`, `b_valid`, `r_valid` and `proto_err` are all low while no valid input is driven.
- R2: `MEM_BASE` is subtracted from a request address. The row used is (rebased address >> 5) modulo `MEM_ROWS`, so two addresses that are `MEM_ROWS`×32 bytes apart reach the same row.
- R3: A burst has `len`+1 beats. Beat i uses byte address start + (i << size). If two beats of one write fall in the same row, the later beat is the one kept.
- R4: `aw_ready` is never high without `w_ready`, and the first W beat may be taken in the same cycle as its address. No new write address is accepted from the acceptance of one write until its B handshake.
- R5: Write data reaches the array only at the B handshake. A read of the target row that completes before that handshake returns the previous contents.
- R6: `b_valid` rises exactly `LATENCY` cycles after the clock edge that captures the final W beat. `b_id` equals the write's `aw_id`, and `b_resp` is 2'b00.
- R7: The first `r_valid` rises exactly `LATENCY` cycles after the AR handshake edge. Each beat carries `r_id` equal to `ar_id`, the stored row data and `r_resp` 2'b00. `r_last` is high only on the final beat.
- R8: `ar_ready` stays low from an AR handshake until the handshake of that burst's final R beat.
- R9: `w_strb` has no effect: every beat overwrites its full 256-bit row, even with all strobes low.
- R10: While `b_valid` or `r_valid` is high and its ready is low, the valid stays high and the ID (and `r_last`) hold steady.
- R11: `proto_err` becomes high and stays high until reset in two cases. The first is a write whose `aw_burst` is neither 1 (incrementing) nor 2 (wrapping). The second is a wrapping write whose low six address bits are not zero. A W beat whose `w_last` differs from (beat index == `aw_len`) also sets it. Legal writes leave it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write start byte address |
| aw_len | input | LEN_W | Write beats minus one |
| aw_size | input | 3 | Log2 of bytes per write beat |
| aw_burst | input | 2 | Write burst type |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write beat data |
| w_strb | input | DATA_W/8 | Byte strobes (ignored) |
| w_last | input | 1 | Final write beat marker |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | ID_W | Write response ID |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Read start byte address |
| ar_len | input | LEN_W | Read beats minus one |
| ar_size | input | 3 | Log2 of bytes per read beat |
| ar_burst | input | 2 | Read burst type (unused) |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | output | ID_W | Read response ID |
| r_data | output | DATA_W | Read beat data |
| r_resp | output | 2 | Read response code |
| r_last | output | 1 | Final read beat marker |
| proto_err | output | 1 | Sticky protocol error flag |

## Verification
The hardest case to reach from the ports is a read that lands on a row while a write to that same row is complete and waiting for its response. The bench gets there by finishing a write and withholding `b_ready`. It then issues a read of the same row and expects the old contents. Only after that does it release the response and read again to see the new data. A second hard case is an address arriving while a read is stalled. The bench holds `r_ready` low, presents a new AR and watches `ar_ready` stay low until the final beat of the first burst is taken.

// File: rtl/lms_pkg.sv
package lms_pkg;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_COLLECT,
        WS_WAIT,
        WS_RESP
    } wr_state_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_WAIT,
        RS_SEND
    } rd_state_e;

    localparam logic [1:0] BURST_INCR = 2'd1;
    localparam logic [1:0] BURST_WRAP = 2'd2;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam int         WRAP_ALIGN = 6;

endpackage

// File: rtl/lms_wr_path.sv
module lms_wr_path
    import lms_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 256,
    parameter int ID_W    = 4,
    parameter int LEN_W   = 4,
    parameter int LATENCY = 90,
    parameter logic [ADDR_W-1:0] MEM_BASE = 'h8000_0000,
    localparam int BUF_BEATS = 1 << LEN_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              aw_valid_i,
    output logic                              aw_ready_o,
    input  logic [ID_W-1:0]                   aw_id_i,
    input  logic [ADDR_W-1:0]                 aw_addr_i,
    input  logic [LEN_W-1:0]                  aw_len_i,
    input  logic [2:0]                        aw_size_i,
    input  logic [1:0]                        aw_burst_i,
    input  logic                              w_valid_i,
    output logic                              w_ready_o,
    input  logic [DATA_W-1:0]                 w_data_i,
    input  logic                              w_last_i,
    output logic                              b_valid_o,
    input  logic                              b_ready_i,
    output logic [ID_W-1:0]                   b_id_o,
    output logic                              commit_o,
    output logic [ADDR_W-1:0]                 commit_addr_o,
    output logic [LEN_W-1:0]                  commit_len_o,
    output logic [2:0]                        commit_size_o,
    output logic [BUF_BEATS-1:0][DATA_W-1:0]  commit_data_o,
    output logic                              err_o
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        wr_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [ID_W-1:0]    id;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   len;
        logic [2:0]         size;
        logic [LEN_W-1:0]   beat;
        logic               err;
    } wr_regs_t;

    wr_regs_t q, d;

    logic [BUF_BEATS-1:0][DATA_W-1:0] wbuf_q;
    logic                             buf_we;
    logic [LEN_W-1:0]                 buf_idx;
    logic [LEN_W-1:0]                 beat_now;
    logic [LEN_W-1:0]                 len_now;
    logic                             last_now;
    logic                             burst_ok;

    always_comb begin
        d        = q;
        buf_we   = 1'b0;
        commit_o = 1'b0;

        aw_ready_o = (q.st == WS_IDLE) && aw_valid_i;
        w_ready_o  = (q.st == WS_COLLECT) || aw_ready_o;
        b_valid_o  = (q.st == WS_RESP);

        beat_now = (q.st == WS_IDLE) ? '0 : q.beat;
        len_now  = (q.st == WS_IDLE) ? aw_len_i : q.len;
        last_now = (beat_now == len_now);
        buf_idx  = beat_now;

        burst_ok = (aw_burst_i == BURST_INCR) ||
                   ((aw_burst_i == BURST_WRAP) && (aw_addr_i[WRAP_ALIGN-1:0] == '0));

        case (q.st)
            WS_IDLE: begin
                if (aw_valid_i) begin
                    d.id   = aw_id_i;
                    d.addr = aw_addr_i - MEM_BASE;
                    d.len  = aw_len_i;
                    d.size = aw_size_i;
                    d.beat = '0;
                    d.st   = WS_COLLECT;
                    if (!burst_ok) d.err = 1'b1;
                end
            end
            WS_COLLECT: ;
            WS_WAIT: begin
                if (q.cnt == '0) d.st  = WS_RESP;
                else             d.cnt = q.cnt - 1'b1;
            end
            WS_RESP: begin
                if (b_ready_i) begin
                    commit_o = 1'b1;
                    d.st     = WS_IDLE;
                end
            end
            default: d.st = WS_IDLE;
        endcase

        if (w_valid_i && w_ready_o) begin
            buf_we = 1'b1;
            if (w_last_i != last_now) d.err = 1'b1;
            if (last_now) begin
                d.st  = WS_WAIT;
                d.cnt = CNT_W'(LATENCY - 1);
            end else begin
                d.beat = beat_now + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: WS_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) wbuf_q[buf_idx] <= w_data_i;
    end

    assign b_id_o        = q.id;
    assign commit_addr_o = q.addr;
    assign commit_len_o  = q.len;
    assign commit_size_o = q.size;
    assign commit_data_o = wbuf_q;
    assign err_o         = q.err;

endmodule

// File: rtl/lms_rd_path.sv
module lms_rd_path
    import lms_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 256,
    parameter int ID_W    = 4,
    parameter int LEN_W   = 4,
    parameter int LATENCY = 90,
    parameter logic [ADDR_W-1:0] MEM_BASE = 'h8000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ar_valid_i,
    output logic               ar_ready_o,
    input  logic [ID_W-1:0]    ar_id_i,
    input  logic [ADDR_W-1:0]  ar_addr_i,
    input  logic [LEN_W-1:0]   ar_len_i,
    input  logic [2:0]         ar_size_i,
    output logic               r_valid_o,
    input  logic               r_ready_i,
    output logic [ID_W-1:0]    r_id_o,
    output logic [DATA_W-1:0]  r_data_o,
    output logic               r_last_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    input  logic [DATA_W-1:0]  rd_data_i
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        rd_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [ID_W-1:0]    id;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   len;
        logic [2:0]         size;
        logic [LEN_W-1:0]   beat;
    } rd_regs_t;

    rd_regs_t q, d;
    logic     final_beat;

    always_comb begin
        d          = q;
        ar_ready_o = (q.st == RS_IDLE) && ar_valid_i;
        r_valid_o  = (q.st == RS_SEND);
        final_beat = (q.beat == q.len);
        r_last_o   = r_valid_o && final_beat;

        case (q.st)
            RS_IDLE: begin
                if (ar_valid_i) begin
                    d.id   = ar_id_i;
                    d.addr = ar_addr_i - MEM_BASE;
                    d.len  = ar_len_i;
                    d.size = ar_size_i;
                    d.beat = '0;
                    d.cnt  = CNT_W'(LATENCY - 1);
                    d.st   = RS_WAIT;
                end
            end
            RS_WAIT: begin
                if (q.cnt == '0) d.st  = RS_SEND;
                else             d.cnt = q.cnt - 1'b1;
            end
            RS_SEND: begin
                if (r_ready_i) begin
                    if (final_beat) d.st   = RS_IDLE;
                    else            d.beat = q.beat + 1'b1;
                end
            end
            default: d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: RS_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o = q.addr + (ADDR_W'(q.beat) << q.size);
    assign r_id_o    = q.id;
    assign r_data_o  = rd_data_i;

endmodule

// File: rtl/lms_mem.sv
module lms_mem #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 256,
    parameter int LEN_W    = 4,
    parameter int MEM_ROWS = 64,
    localparam int BUF_BEATS = 1 << LEN_W
) (
    input  logic                              clk,
    input  logic                              commit_i,
    input  logic [ADDR_W-1:0]                 commit_addr_i,
    input  logic [LEN_W-1:0]                  commit_len_i,
    input  logic [2:0]                        commit_size_i,
    input  logic [BUF_BEATS-1:0][DATA_W-1:0]  commit_data_i,
    input  logic [ADDR_W-1:0]                 rd_addr_i,
    output logic [DATA_W-1:0]                 rd_data_o
);

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int ROW_W  = $clog2(MEM_ROWS);

    logic [DATA_W-1:0] rows_q [MEM_ROWS];
    logic [ROW_W-1:0]  beat_row [BUF_BEATS];

    for (genvar g = 0; g < BUF_BEATS; g++) begin : g_beat_row
        assign beat_row[g] = ROW_W'((commit_addr_i + (ADDR_W'(g) << commit_size_i)) >> BYTE_W);
    end

    always_ff @(posedge clk) begin
        if (commit_i) begin
            for (int i = 0; i < BUF_BEATS; i++) begin
                if (i <= int'(commit_len_i)) rows_q[beat_row[i]] <= commit_data_i[i];
            end
        end
    end

    assign rd_data_o = rows_q[ROW_W'(rd_addr_i >> BYTE_W)];

endmodule

// File: rtl/lat_mem_slave.sv
module lat_mem_slave
    import lms_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 256,
    parameter int ID_W     = 4,
    parameter int LEN_W    = 4,
    parameter int LATENCY  = 90,
    parameter int MEM_ROWS = 64,
    parameter logic [ADDR_W-1:0] MEM_BASE = 'h8000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 aw_valid,
    output logic                 aw_ready,
    input  logic [ID_W-1:0]      aw_id,
    input  logic [ADDR_W-1:0]    aw_addr,
    input  logic [LEN_W-1:0]     aw_len,
    input  logic [2:0]           aw_size,
    input  logic [1:0]           aw_burst,
    input  logic                 w_valid,
    output logic                 w_ready,
    input  logic [DATA_W-1:0]    w_data,
    input  logic [DATA_W/8-1:0]  w_strb,
    input  logic                 w_last,
    output logic                 b_valid,
    input  logic                 b_ready,
    output logic [ID_W-1:0]      b_id,
    output logic [1:0]           b_resp,
    input  logic                 ar_valid,
    output logic                 ar_ready,
    input  logic [ID_W-1:0]      ar_id,
    input  logic [ADDR_W-1:0]    ar_addr,
    input  logic [LEN_W-1:0]     ar_len,
    input  logic [2:0]           ar_size,
    input  logic [1:0]           ar_burst,
    output logic                 r_valid,
    input  logic                 r_ready,
    output logic [ID_W-1:0]      r_id,
    output logic [DATA_W-1:0]    r_data,
    output logic [1:0]           r_resp,
    output logic                 r_last,
    output logic                 proto_err
);

    localparam int BUF_BEATS = 1 << LEN_W;

    logic                             commit;
    logic [ADDR_W-1:0]                commit_addr;
    logic [LEN_W-1:0]                 commit_len;
    logic [2:0]                       commit_size;
    logic [BUF_BEATS-1:0][DATA_W-1:0] commit_data;
    logic [ADDR_W-1:0]                rd_addr;
    logic [DATA_W-1:0]                rd_data;
    logic                             unused_inputs;

    assign unused_inputs = ^{w_strb, ar_burst};

    lms_wr_path #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W),
        .LATENCY(LATENCY), .MEM_BASE(MEM_BASE)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .aw_valid_i(aw_valid), .aw_ready_o(aw_ready), .aw_id_i(aw_id),
        .aw_addr_i(aw_addr), .aw_len_i(aw_len), .aw_size_i(aw_size),
        .aw_burst_i(aw_burst),
        .w_valid_i(w_valid), .w_ready_o(w_ready), .w_data_i(w_data),
        .w_last_i(w_last),
        .b_valid_o(b_valid), .b_ready_i(b_ready), .b_id_o(b_id),
        .commit_o(commit), .commit_addr_o(commit_addr),
        .commit_len_o(commit_len), .commit_size_o(commit_size),
        .commit_data_o(commit_data), .err_o(proto_err)
    );

    lms_rd_path #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W),
        .LATENCY(LATENCY), .MEM_BASE(MEM_BASE)
    ) u_rd (
        .clk(clk), .rst_n(rst_n),
        .ar_valid_i(ar_valid), .ar_ready_o(ar_ready), .ar_id_i(ar_id),
        .ar_addr_i(ar_addr), .ar_len_i(ar_len), .ar_size_i(ar_size),
        .r_valid_o(r_valid), .r_ready_i(r_ready), .r_id_o(r_id),
        .r_data_o(r_data), .r_last_o(r_last),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    lms_mem #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .MEM_ROWS(MEM_ROWS)
    ) u_mem (
        .clk(clk),
        .commit_i(commit), .commit_addr_i(commit_addr),
        .commit_len_i(commit_len), .commit_size_i(commit_size),
        .commit_data_i(commit_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    assign b_resp = RESP_OKAY;
    assign r_resp = RESP_OKAY;

endmodule

// File: rtl/lms_chk.sv
module lms_chk #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            aw_ready,
    input logic            w_ready,
    input logic            b_valid,
    input logic            b_ready,
    input logic [ID_W-1:0] b_id,
    input logic [1:0]      b_resp,
    input logic            ar_ready,
    input logic            r_valid,
    input logic            r_ready,
    input logic [ID_W-1:0] r_id,
    input logic [1:0]      r_resp,
    input logic            r_last,
    input logic            proto_err
);

    p_aw_with_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
        aw_ready |-> w_ready);

    p_no_aw_during_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> !aw_ready);

    p_bresp_okay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (b_resp == 2'b00));

    p_rresp_okay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> (r_resp == 2'b00));

    p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> !ar_ready);

    p_b_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_id)));

    p_r_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_id) && $stable(r_last)));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

bind lat_mem_slave lms_chk #(.ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .aw_ready(aw_ready), .w_ready(w_ready),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .ar_ready(ar_ready),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_resp(r_resp),
    .r_last(r_last), .proto_err(proto_err)
);

// File: tb/lat_mem_slave_tb.sv
`timescale 1ns/1ps
module lat_mem_slave_tb;

    localparam int          LAT  = 12;
    localparam int          ROWS = 64;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         aw_valid = 1'b0, aw_ready;
    logic [3:0]   aw_id = '0;
    logic [31:0]  aw_addr = '0;
    logic [3:0]   aw_len = '0;
    logic [2:0]   aw_size = '0;
    logic [1:0]   aw_burst = '0;
    logic         w_valid = 1'b0, w_ready;
    logic [255:0] w_data = '0;
    logic [31:0]  w_strb = '0;
    logic         w_last = 1'b0;
    logic         b_valid, b_ready = 1'b0;
    logic [3:0]   b_id;
    logic [1:0]   b_resp;
    logic         ar_valid = 1'b0, ar_ready;
    logic [3:0]   ar_id = '0;
    logic [31:0]  ar_addr = '0;
    logic [3:0]   ar_len = '0;
    logic [2:0]   ar_size = '0;
    logic [1:0]   ar_burst = 2'd1;
    logic         r_valid, r_ready = 1'b1;
    logic [3:0]   r_id;
    logic [255:0] r_data;
    logic [1:0]   r_resp;
    logic         r_last;
    logic         proto_err;

    lat_mem_slave #(.LATENCY(LAT), .MEM_ROWS(ROWS), .MEM_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
        .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
        .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
        .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
        .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
        .r_resp(r_resp), .r_last(r_last), .proto_err(proto_err)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0]   id;
        logic [255:0] data;
        logic         last;
        string        req;
    } exp_t;

    exp_t         sq[$];
    logic [255:0] model [int];
    logic [255:0] pend_data [16];
    logic [31:0]  pend_addr;
    int           pend_n;
    int           pend_size;

    task automatic check_eq(string req, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] pat(int s, int i);
        return {8{16'(s), 16'(i * 7 + 3)}} ^ {32{8'(s * 13 + i)}};
    endfunction

    function automatic int rowof(logic [31:0] a);
        return int'(((a - BASE) >> 5) & (ROWS - 1));
    endfunction

    function automatic logic [255:0] peek(int row);
        return model.exists(row) ? model[row] : '0;
    endfunction

    // Scoreboard monitor: compares each accepted R beat with the queue head
    always @(negedge clk) begin
        #1;
        if (rst_n && r_valid && r_ready) begin
            if (sq.size() == 0) begin
                check_eq("R7", "unexpected read beat", 256'(r_id), 256'hF);
            end else begin
                exp_t e;
                e = sq.pop_front();
                check_eq(e.req, "r_id", 256'(r_id), 256'(e.id));
                check_eq(e.req, "r_data", r_data, e.data);
                check_eq(e.req, "r_last", 256'(r_last), 256'(e.last));
                check_eq("R7", "r_resp", 256'(r_resp), 256'(0));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] id, input logic [31:0] addr,
                            input int len, input int size, input logic [1:0] burst,
                            input int seed, input logic [31:0] strb, input bit bad_last,
                            output int fire_cyc);
        @(negedge clk);
        aw_valid = 1'b1; aw_id = id; aw_addr = addr; aw_len = 4'(len);
        aw_size = 3'(size); aw_burst = burst;
        for (int i = 0; i <= len; i++) begin
            if (i > 0) begin
                @(negedge clk);
                aw_valid = 1'b0;
            end
            w_valid = 1'b1; w_data = pat(seed, i); w_strb = strb;
            w_last = (i == len) ^ bad_last;
            pend_data[i] = pat(seed, i);
            #1;
            while (!w_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        aw_valid = 1'b0; w_valid = 1'b0; w_last = 1'b0;
        fire_cyc = cyc;
        pend_addr = addr; pend_n = len + 1; pend_size = size;
    endtask

    task automatic take_b(input logic [3:0] id, input int fire_cyc, input bit chk_lat);
        while (!b_valid) @(negedge clk);
        if (chk_lat) check_eq("R6", "b_valid latency", 256'(cyc - fire_cyc), 256'(LAT));
        check_eq("R6", "b_id", 256'(b_id), 256'(id));
        check_eq("R6", "b_resp", 256'(b_resp), 256'(0));
        b_ready = 1'b1;
        @(negedge clk);
        b_ready = 1'b0;
        for (int i = 0; i < pend_n; i++)
            model[rowof(pend_addr + (32'(i) << pend_size))] = pend_data[i];
    endtask

    task automatic push_read(input logic [3:0] id, input logic [31:0] addr,
                             input int len, input int size, input string req);
        for (int i = 0; i <= len; i++) begin
            exp_t e;
            e.id = id; e.last = (i == len); e.req = req;
            e.data = peek(rowof(addr + (32'(i) << size)));
            sq.push_back(e);
        end
    endtask

    task automatic do_read(input logic [3:0] id, input logic [31:0] addr,
                           input int len, input int size, input string req);
        int f;
        push_read(id, addr, len, size, req);
        @(negedge clk);
        ar_valid = 1'b1; ar_id = id; ar_addr = addr; ar_len = 4'(len); ar_size = 3'(size);
        #1;
        while (!ar_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        ar_valid = 1'b0;
        f = cyc;
        while (!r_valid) @(negedge clk);
        check_eq("R7", "r_valid latency", 256'(cyc - f), 256'(LAT));
        while (sq.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int f;
        do_reset();

        // R1: idle outputs after reset
        #1;
        check_eq("R1", "aw_ready", 256'(aw_ready), 256'(0));
        check_eq("R1", "w_ready", 256'(w_ready), 256'(0));
        check_eq("R1", "ar_ready", 256'(ar_ready), 256'(0));
        check_eq("R1", "b_valid", 256'(b_valid), 256'(0));
        check_eq("R1", "r_valid", 256'(r_valid), 256'(0));
        check_eq("R1", "proto_err", 256'(proto_err), 256'(0));

        // R3/R6: four-beat incrementing write
        do_write(4'd3, BASE + 32'h100, 3, 5, 2'd1, 1, '1, 1'b0, f);
        // R4: no new address while the write awaits its response
        aw_valid = 1'b1; aw_burst = 2'd1;
        #1;
        check_eq("R4", "aw_ready while write pending", 256'(aw_ready), 256'(0));
        check_eq("R4", "w_ready while write pending", 256'(w_ready), 256'(0));
        aw_valid = 1'b0;
        take_b(4'd3, f, 1'b1);
        do_read(4'd5, BASE + 32'h100, 3, 5, "R3");

        // R2: an address one array size above aliases onto the same row
        do_write(4'd1, BASE + 32'(ROWS * 32) + 32'h40, 0, 5, 2'd1, 5, '1, 1'b0, f);
        take_b(4'd1, f, 1'b1);
        do_read(4'd2, BASE + 32'h40, 0, 5, "R2");

        // R5: write held before B; a read sees old data, then new after B
        do_write(4'd2, BASE + 32'h100, 0, 5, 2'd1, 9, '1, 1'b0, f);
        do_read(4'd4, BASE + 32'h100, 0, 5, "R5");
        check_eq("R10", "b_valid held while b_ready low", 256'(b_valid), 256'(1));
        take_b(4'd2, f, 1'b0);
        do_read(4'd4, BASE + 32'h100, 0, 5, "R5");

        // R3: half-width beats land in one row, later beat kept
        do_write(4'd6, BASE + 32'h300, 1, 4, 2'd1, 6, '1, 1'b0, f);
        take_b(4'd6, f, 1'b1);
        do_read(4'd6, BASE + 32'h300, 0, 5, "R3");

        // R9: zero strobes still write the full beat
        do_write(4'd7, BASE + 32'h400, 0, 5, 2'd1, 11, '0, 1'b0, f);
        take_b(4'd7, f, 1'b1);
        do_read(4'd7, BASE + 32'h400, 0, 5, "R9");

        // R8/R10: stalled read burst blocks a second address
        r_ready = 1'b0;
        push_read(4'd8, BASE + 32'h100, 1, 5, "R8");
        @(negedge clk);
        ar_valid = 1'b1; ar_id = 4'd8; ar_addr = BASE + 32'h100; ar_len = 4'd1; ar_size = 3'd5;
        #1;
        while (!ar_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        ar_valid = 1'b0;
        while (!r_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        check_eq("R10", "r_valid held while stalled", 256'(r_valid), 256'(1));
        check_eq("R10", "r_id held while stalled", 256'(r_id), 256'(8));
        push_read(4'd9, BASE + 32'h400, 0, 5, "R8");
        ar_valid = 1'b1; ar_id = 4'd9; ar_addr = BASE + 32'h400; ar_len = 4'd0;
        #1;
        check_eq("R8", "ar_ready while read outstanding", 256'(ar_ready), 256'(0));
        @(negedge clk);
        r_ready = 1'b1;
        #1;
        while (!ar_ready) begin
            @(negedge clk);
            #1;
        end
        check_eq("R8", "first burst drained before ar_ready", 256'(sq.size()), 256'(1));
        @(negedge clk);
        ar_valid = 1'b0;
        while (sq.size() > 0) @(negedge clk);
        @(negedge clk);

        // R11: legal wrapping write keeps the flag low, misaligned one sets it
        do_write(4'd1, BASE + 32'h200, 1, 5, 2'd2, 12, '1, 1'b0, f);
        take_b(4'd1, f, 1'b1);
        check_eq("R11", "aligned wrap no error", 256'(proto_err), 256'(0));
        do_write(4'd1, BASE + 32'h220, 1, 5, 2'd2, 13, '1, 1'b0, f);
        take_b(4'd1, f, 1'b1);
        check_eq("R11", "misaligned wrap error", 256'(proto_err), 256'(1));
        repeat (3) @(negedge clk);
        check_eq("R11", "error sticky", 256'(proto_err), 256'(1));

        do_reset();
        check_eq("R1", "proto_err cleared by reset", 256'(proto_err), 256'(0));
        do_write(4'd2, BASE + 32'h500, 1, 5, 2'd1, 14, '1, 1'b1, f);
        take_b(4'd2, f, 1'b1);
        check_eq("R11", "w_last mismatch error", 256'(proto_err), 256'(1));

        do_reset();
        do_write(4'd3, BASE + 32'h600, 0, 5, 2'd0, 15, '1, 1'b0, f);
        take_b(4'd3, f, 1'b1);
        check_eq("R11", "fixed burst error", 256'(proto_err), 256'(1));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule